// File: doc/BRIEF.md
# Control Port Command Runner

This block issues single commands to the control port of a processor core and waits for each to finish. A descriptor is handed over on a valid/ready handshake. It holds a function code, a register number, write data, an optional expected read value with a don't-care mask, flags that say whether a command error or a memory error is expected, and a wait kind. The block latches the descriptor and raises a one-cycle request that carries the function, the register and the data. It then watches the status flags of the port until the completion condition for that wait kind holds, or until the wait budget for that kind runs out.

When the command ends, the block gives a one-cycle done strobe with a verdict (pass, fail or timeout) and the number of cycles the command took. The count starts at the request cycle. On a timeout the block also pulses a reset to the core and then stays busy for a fixed recovery period before it takes the next descriptor. The three wait budgets start from fixed defaults and can be rewritten at run time through a small configuration write port.

Top module: `ctlport_cmd_runner`

## Requirements
- R1: `cmd_ready` is high only while idle. A descriptor is taken when `cmd_valid` and `cmd_ready` are both high. The next cycle `port_req` is high for exactly one cycle with `port_func`, `port_reg` and `port_din` equal to the descriptor. `cmd_valid` while not ready has no effect, and `port_func` stays unchanged until the command ends.
- R2: Wait kind 0 (plain), and the spare code 3, completes in the first waiting cycle that has `port_ack` high.
- R3: Wait kind 1 (single step) completes only in a waiting cycle with both `port_busy` and `port_step` low.
- R4: Wait kind 2 (run until halt) completes only in a waiting cycle with both `port_busy` and `port_run` low.
- R5: The wait budgets after reset are 50 cycles (plain), 100 (step) and 5000 (run until halt). The budget is the number of waiting cycles that follow the request cycle. If the condition is still unmet in the last of them, the verdict is timeout (code 2). A completion in that last cycle still counts as a completion.
- R6: A write with `cfg_we` stores `cfg_val` as the budget for slot `cfg_sel` (0 plain, 1 step, 2 run until halt; 3 is ignored). It applies from the next accepted descriptor. A stored 0 acts as 1.
- R7: With `cmd_chk` set, the data check passes when `((port_dout ^ cmd_exp) & ~cmd_msk) == 0`, so set mask bits are don't-care. A mismatch gives fail (code 1). With `cmd_chk` clear, the data is not judged.
- R8: The error flags are judged in the completion cycle, before the data check. If `port_err` or `cmd_err_exp` is set, the verdict is pass (code 0) only when both are set, and fail otherwise. Otherwise the same rule applies to `port_merr` and `cmd_merr_exp`. Otherwise the data check decides.
- R9: On a timeout, `cpu_rst` is high for exactly one cycle, in the same cycle as the done strobe. `cmd_ready` then stays low for the 9 cycles after it and returns high in the cycle after those.
- R10: `res_done` is high for one cycle, the cycle after the completion or timeout cycle. `res_cycles` equals the number of waiting cycles used plus one, so a completion in the first waiting cycle reports 2 and a timeout with budget T reports T+1.
- R11: After reset `cmd_ready` is high and `port_req`, `cpu_rst` and `res_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Budget write strobe |
| cfg_sel | input | 2 | Budget slot select |
| cfg_val | input | 16 | New budget value |
| cmd_valid | input | 1 | Descriptor valid |
| cmd_ready | output | 1 | Descriptor can be taken |
| cmd_func | input | 5 | Function code |
| cmd_reg | input | 3 | Register number |
| cmd_wdata | input | 16 | Write data |
| cmd_chk | input | 1 | Enable read data check |
| cmd_exp | input | 16 | Expected read data |
| cmd_msk | input | 16 | Don't-care mask for the check |
| cmd_wait | input | 2 | Wait kind |
| cmd_err_exp | input | 1 | Command error expected |
| cmd_merr_exp | input | 1 | Memory error expected |
| port_req | output | 1 | One-cycle command request |
| port_func | output | 5 | Function code to the port |
| port_reg | output | 3 | Register number to the port |
| port_din | output | 16 | Write data to the port |
| port_ack | input | 1 | Command acknowledge flag |
| port_busy | input | 1 | Port busy flag |
| port_err | input | 1 | Command error flag |
| port_merr | input | 1 | Memory error flag |
| port_run | input | 1 | Core running flag |
| port_step | input | 1 | Core stepping flag |
| port_dout | input | 16 | Read data from the port |
| cpu_rst | output | 1 | Reset pulse after a timeout |
| res_done | output | 1 | Result strobe |
| res_verdict | output | 2 | 0 pass, 1 fail, 2 timeout |
| res_cycles | output | 17 | Cycles used, request cycle included |

## Verification
Completion and timeout can fall in the same cycle: the condition for the wait kind can turn true in the very last waiting cycle of the budget. The bench provokes this with a responder that raises the finishing flags exactly in waiting cycle T-1, and also one cycle later. It does this with the default budgets and with budgets shrunk at run time to 3 and to 0. The first case must report a completion with T+1 cycles and no reset pulse. The second must report a timeout with the same count, followed by the reset pulse and the recovery hold.

// File: rtl/cmdrun_pkg.sv
package cmdrun_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    WK_PLAIN = 2'd0,
    WK_STEP  = 2'd1,
    WK_HALT  = 2'd2,
    WK_SPARE = 2'd3
  } wait_kind_e;

  typedef enum logic [1:0] {
    VD_PASS = 2'd0,
    VD_FAIL = 2'd1,
    VD_TMO  = 2'd2,
    VD_NONE = 2'd3
  } verdict_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RST,
    ST_HOLD
  } run_state_e;

  // Masked comparison: set bits of dc are ignored.
  function automatic logic masked_match(input logic [DATA_W-1:0] got,
                                        input logic [DATA_W-1:0] want,
                                        input logic [DATA_W-1:0] dc);
    return ((got ^ want) & ~dc) == '0;
  endfunction

  // Verdict of one error flag pair; VD_NONE when neither side is set.
  function automatic verdict_e flag_pair(input logic seen, input logic expd);
    if (!seen && !expd) return VD_NONE;
    return (seen && expd) ? VD_PASS : VD_FAIL;
  endfunction

endpackage

// File: rtl/cmdrun_limits.sv
module cmdrun_limits
  import cmdrun_pkg::*;
#(
  parameter int TO_W     = 16,
  parameter int DEF_PLN  = 50,
  parameter int DEF_STP  = 100,
  parameter int DEF_HLT  = 5000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [TO_W-1:0] cfg_val,
  input  wait_kind_e      kind,
  output logic [TO_W-1:0] limit
);
  localparam int NSLOT = 3;
  localparam logic [TO_W-1:0] DEFS [NSLOT] =
    '{TO_W'(DEF_PLN), TO_W'(DEF_STP), TO_W'(DEF_HLT)};

  logic [TO_W-1:0] slot_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot_q[i] <= DEFS[i];
      else if (cfg_we && cfg_sel == 2'(i)) slot_q[i] <= cfg_val;
    end
  end

  // A budget of zero waiting cycles is stretched to one.
  function automatic logic [TO_W-1:0] eff_limit(input logic [TO_W-1:0] raw);
    return (raw == '0) ? TO_W'(1) : raw;
  endfunction

  always_comb begin
    unique case (kind)
      WK_STEP: limit = eff_limit(slot_q[1]);
      WK_HALT: limit = eff_limit(slot_q[2]);
      default: limit = eff_limit(slot_q[0]);
    endcase
  end

endmodule

// File: rtl/cmdrun_finish.sv
module cmdrun_finish
  import cmdrun_pkg::*;
(
  input  wait_kind_e kind,
  input  logic       ack,
  input  logic       busy,
  input  logic       run,
  input  logic       step,
  output logic       met
);
  always_comb begin
    unique case (kind)
      WK_STEP: met = !busy && !step;
      WK_HALT: met = !busy && !run;
      default: met = ack;
    endcase
  end
endmodule

// File: rtl/cmdrun_judge.sv
module cmdrun_judge
  import cmdrun_pkg::*;
(
  input  logic              err,
  input  logic              err_exp,
  input  logic              merr,
  input  logic              merr_exp,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] dout,
  input  logic [DATA_W-1:0] want,
  input  logic [DATA_W-1:0] dc,
  output verdict_e          verdict
);
  verdict_e e_vd, m_vd;

  always_comb begin
    e_vd = flag_pair(err, err_exp);
    m_vd = flag_pair(merr, merr_exp);
    if (e_vd != VD_NONE)      verdict = e_vd;
    else if (m_vd != VD_NONE) verdict = m_vd;
    else if (chk_en)          verdict = masked_match(dout, want, dc) ? VD_PASS : VD_FAIL;
    else                      verdict = VD_PASS;
  end
endmodule

// File: rtl/ctlport_cmd_runner.sv
module ctlport_cmd_runner
  import cmdrun_pkg::*;
#(
  parameter int FUNC_W   = 5,
  parameter int REG_W    = 3,
  parameter int TO_W     = 16,
  parameter int TO_PLAIN = 50,
  parameter int TO_STEP  = 100,
  parameter int TO_HALT  = 5000,
  parameter int HOLD_CYC = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [TO_W-1:0]   cfg_val,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [15:0]       cmd_wdata,
  input  logic              cmd_chk,
  input  logic [15:0]       cmd_exp,
  input  logic [15:0]       cmd_msk,
  input  logic [1:0]        cmd_wait,
  input  logic              cmd_err_exp,
  input  logic              cmd_merr_exp,
  output logic              port_req,
  output logic [FUNC_W-1:0] port_func,
  output logic [REG_W-1:0]  port_reg,
  output logic [15:0]       port_din,
  input  logic              port_ack,
  input  logic              port_busy,
  input  logic              port_err,
  input  logic              port_merr,
  input  logic              port_run,
  input  logic              port_step,
  input  logic [15:0]       port_dout,
  output logic              cpu_rst,
  output logic              res_done,
  output logic [1:0]        res_verdict,
  output logic [TO_W:0]     res_cycles
);
  localparam int CNT_W  = TO_W + 1;
  localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  run_state_e        st_q;
  logic [FUNC_W-1:0] d_func;
  logic [REG_W-1:0]  d_reg;
  logic [15:0]       d_wdata, d_exp, d_msk;
  logic              d_chk, d_eexp, d_mexp;
  wait_kind_e        d_kind;
  logic [TO_W-1:0]   lim_q, wcnt_q;
  logic [HOLD_W-1:0] hcnt_q;
  logic              done_q;
  verdict_e          vd_q;
  logic [CNT_W-1:0]  cyc_q;

  // Named internal events.
  logic       accept, cond_met, done_ok, tmo_hit, last_slot;
  logic [TO_W-1:0] lim_sel;
  verdict_e   judged;

  cmdrun_limits #(.TO_W(TO_W), .DEF_PLN(TO_PLAIN), .DEF_STP(TO_STEP), .DEF_HLT(TO_HALT)) u_lim (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .kind(wait_kind_e'(cmd_wait)), .limit(lim_sel)
  );

  cmdrun_finish u_fin (
    .kind(d_kind), .ack(port_ack), .busy(port_busy), .run(port_run), .step(port_step),
    .met(cond_met)
  );

  cmdrun_judge u_jdg (
    .err(port_err), .err_exp(d_eexp), .merr(port_merr), .merr_exp(d_mexp),
    .chk_en(d_chk), .dout(port_dout), .want(d_exp), .dc(d_msk), .verdict(judged)
  );

  function automatic logic [CNT_W-1:0] used_cycles(input logic [TO_W-1:0] waited);
    return CNT_W'(waited) + CNT_W'(2);
  endfunction

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign last_slot = (wcnt_q == lim_q - TO_W'(1));
  assign done_ok   = (st_q == ST_WAIT) && cond_met;
  assign tmo_hit   = (st_q == ST_WAIT) && !cond_met && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_func <= '0; d_reg <= '0; d_wdata <= '0; d_exp <= '0; d_msk <= '0;
      d_chk  <= 1'b0; d_eexp <= 1'b0; d_mexp <= 1'b0; d_kind <= WK_PLAIN;
      lim_q  <= TO_W'(1);
    end else if (accept) begin
      d_func <= cmd_func; d_reg <= cmd_reg; d_wdata <= cmd_wdata;
      d_exp  <= cmd_exp;  d_msk <= cmd_msk; d_chk <= cmd_chk;
      d_eexp <= cmd_err_exp; d_mexp <= cmd_merr_exp;
      d_kind <= wait_kind_e'(cmd_wait);
      lim_q  <= lim_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      hcnt_q <= '0;
      done_q <= 1'b0;
      vd_q   <= VD_PASS;
      cyc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE:  if (accept) st_q <= ST_ISSUE;
        ST_ISSUE: begin
          wcnt_q <= '0;
          st_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (done_ok || tmo_hit) begin
            done_q <= 1'b1;
            vd_q   <= done_ok ? judged : VD_TMO;
            cyc_q  <= used_cycles(wcnt_q);
            st_q   <= done_ok ? ST_IDLE : ST_RST;
          end else begin
            wcnt_q <= wcnt_q + TO_W'(1);
          end
        end
        ST_RST: begin
          hcnt_q <= '0;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: begin
          if (hcnt_q == HOLD_W'(HOLD_CYC - 1)) st_q <= ST_IDLE;
          else                                  hcnt_q <= hcnt_q + HOLD_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign port_req    = (st_q == ST_ISSUE);
  assign port_func   = d_func;
  assign port_reg    = d_reg;
  assign port_din    = d_wdata;
  assign cpu_rst     = (st_q == ST_RST);
  assign res_done    = done_q;
  assign res_verdict = vd_q;
  assign res_cycles  = cyc_q;

endmodule

// File: rtl/cmdrun_chk.sv
module cmdrun_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       port_req,
  input logic       cpu_rst,
  input logic       res_done,
  input logic [1:0] res_verdict,
  input logic       done_ok,
  input logic       tmo_hit,
  input logic [1:0] d_kind,
  input logic       port_ack,
  input logic       port_busy,
  input logic       port_run,
  input logic       port_step
);
  // R1
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_req |=> !port_req);
  // R1
  accept_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (port_req && !cmd_ready));
  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_req |-> !cmd_ready);
  // R2
  plain_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_verdict != 2'd2 && (d_kind == 2'd0 || d_kind == 2'd3)) |-> $past(port_ack));
  // R3
  step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_verdict != 2'd2 && d_kind == 2'd1) |-> (!$past(port_busy) && !$past(port_step)));
  // R4
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_verdict != 2'd2 && d_kind == 2'd2) |-> (!$past(port_busy) && !$past(port_run)));
  // R5
  tmo_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (res_done && res_verdict == 2'd2 && cpu_rst));
  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |=> (!cpu_rst && !cmd_ready));
  // R9
  rst_with_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |-> (res_done && res_verdict == 2'd2));
  // R10
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (res_done && res_verdict != 2'd2 && !cpu_rst));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
endmodule

bind ctlport_cmd_runner cmdrun_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .port_req(port_req), .cpu_rst(cpu_rst), .res_done(res_done),
  .res_verdict(res_verdict), .done_ok(done_ok), .tmo_hit(tmo_hit),
  .d_kind(d_kind), .port_ack(port_ack), .port_busy(port_busy),
  .port_run(port_run), .port_step(port_step)
);

// File: tb/sim_ctlport_cmd_runner.sv
`timescale 1ns/1ps
module sim_ctlport_cmd_runner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [15:0] cfg_val = 0;
  logic cmd_valid = 0; logic cmd_ready;
  logic [4:0] cmd_func = 0; logic [2:0] cmd_reg = 0; logic [15:0] cmd_wdata = 0;
  logic cmd_chk = 0; logic [15:0] cmd_exp = 0, cmd_msk = 0; logic [1:0] cmd_wait = 0;
  logic cmd_err_exp = 0, cmd_merr_exp = 0;
  logic port_req; logic [4:0] port_func; logic [2:0] port_reg; logic [15:0] port_din;
  logic port_ack = 0, port_busy = 0, port_err = 0, port_merr = 0, port_run = 0, port_step = 0;
  logic [15:0] port_dout = 0;
  logic cpu_rst, res_done; logic [1:0] res_verdict; logic [16:0] res_cycles;

  int checks = 0, errors = 0;
  int lim_model [4];
  bit finished = 0;

  always #2 clk = ~clk;

  ctlport_cmd_runner u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_verdict(bit err, bit eexp, bit merr, bit mexp, bit chk,
                                     logic [15:0] d, logic [15:0] e, logic [15:0] m);
    if (err || eexp) return (err && eexp) ? 0 : 1;
    if (merr || mexp) return (merr && mexp) ? 0 : 1;
    if (chk) begin
      for (int b = 0; b < 16; b++)
        if (!m[b] && d[b] != e[b]) return 1;
    end
    return 0;
  endfunction

  task automatic set_cfg(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_val = 16'(val);
    @(negedge clk);
    cfg_we = 0;
    lim_model[sel] = (val == 0) ? 1 : val;
    if (sel == 0) lim_model[3] = lim_model[0];
  endtask

  task automatic status_wait(input int kind, input int k);
    port_err = 0; port_merr = 0; port_ack = 0;
    case (kind)
      1: begin port_busy = k[0]; port_step = !k[0]; port_run = 1'($urandom); end
      2: begin port_busy = k[0]; port_run = !k[0]; port_step = 1'($urandom); end
      default: begin port_busy = 1'($urandom); port_run = 1'($urandom); port_step = 1'($urandom); end
    endcase
  endtask

  task automatic status_done(input int kind, input bit err, input bit merr, input logic [15:0] d);
    port_err = err; port_merr = merr; port_dout = d;
    case (kind)
      1: begin port_busy = 0; port_step = 0; port_ack = 0; end
      2: begin port_busy = 0; port_run = 0; port_ack = 0; end
      default: begin port_ack = 1; end
    endcase
  endtask

  task automatic status_idle();
    port_ack = 0; port_busy = 0; port_err = 0; port_merr = 0; port_run = 0; port_step = 0;
  endtask

  task automatic run_cmd(input int kind, input int dly, input bit err, input bit eexp,
                         input bit merr, input bit mexp, input bit chk,
                         input logic [15:0] d, input logic [15:0] e, input logic [15:0] m,
                         input string rq);
    int tl, last, exp_vd;
    logic [4:0] f; logic [2:0] r; logic [15:0] w;
    tl = lim_model[kind];
    last = (dly < tl) ? dly : tl - 1;
    f = 5'($urandom); r = 3'($urandom); w = 16'($urandom);
    @(negedge clk);
    check(cmd_ready == 1, "R1", "ready when idle", cmd_ready, 1);
    cmd_valid = 1; cmd_func = f; cmd_reg = r; cmd_wdata = w; cmd_wait = 2'(kind);
    cmd_chk = chk; cmd_exp = e; cmd_msk = m; cmd_err_exp = eexp; cmd_merr_exp = mexp;
    @(negedge clk);
    cmd_valid = 0;
    check(port_req == 1 && port_func == f && port_reg == r && port_din == w,
          "R1", "request fields", {port_req, port_func, port_reg, port_din}, {1'b1, f, r, w});
    status_wait(kind, 0);
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      if (k == 0) begin
        check(port_req == 0, "R1", "request one cycle", port_req, 0);
        // ignored descriptor during the wait
        cmd_valid = 1; cmd_func = ~f; cmd_reg = ~r; cmd_wait = 2'($urandom);
      end
      if (k == dly) status_done(kind, err, merr, d);
      else status_wait(kind, k + 1);
      if (k == last) begin
        check(port_func == f && cmd_ready == 0, "R1", "descriptor ignored while busy",
              {cmd_ready, port_func}, {1'b0, f});
        cmd_valid = 0;
      end
    end
    @(negedge clk);
    status_idle();
    exp_vd = (dly < tl) ? ref_verdict(err, eexp, merr, mexp, chk, d, e, m) : 2;
    check(res_done == 1, rq, "done strobe", res_done, 1);
    check(res_verdict == 2'(exp_vd), rq, "verdict", res_verdict, exp_vd);
    check(res_cycles == 17'(last + 2), "R10", "cycle count", res_cycles, last + 2);
    if (exp_vd == 2) begin
      check(cpu_rst == 1 && cmd_ready == 0, "R9", "reset pulse", {cpu_rst, cmd_ready}, 2'b10);
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        check(cpu_rst == 0 && cmd_ready == 0, "R9", "recovery hold", {cpu_rst, cmd_ready}, 0);
      end
      @(negedge clk);
      check(cmd_ready == 1, "R9", "ready after hold", cmd_ready, 1);
    end else begin
      check(cpu_rst == 0 && cmd_ready == 1, "R10", "back to idle", {cpu_rst, cmd_ready}, 2'b01);
    end
    @(negedge clk);
    check(res_done == 0, "R10", "strobe one cycle", res_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1357);
    lim_model[0] = 50; lim_model[1] = 100; lim_model[2] = 5000; lim_model[3] = 50;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    check(cmd_ready == 1 && port_req == 0 && cpu_rst == 0 && res_done == 0,
          "R11", "reset state", {cmd_ready, port_req, cpu_rst, res_done}, 4'b1000);

    run_cmd(0, 0,  0,0,0,0, 0, 0, 0, 0, "R2");
    run_cmd(3, 7,  0,0,0,0, 0, 0, 0, 0, "R2");
    run_cmd(0, 49, 0,0,0,0, 0, 0, 0, 0, "R5");
    run_cmd(0, 50, 0,0,0,0, 0, 0, 0, 0, "R5");
    run_cmd(1, 99, 0,0,0,0, 0, 0, 0, 0, "R3");
    run_cmd(1, 100,0,0,0,0, 0, 0, 0, 0, "R5");
    run_cmd(2, 12, 0,0,0,0, 0, 0, 0, 0, "R4");
    run_cmd(2, 5000,0,0,0,0,0, 0, 0, 0, "R5");
    set_cfg(0, 3);
    run_cmd(0, 2, 0,0,0,0, 0, 0, 0, 0, "R6");
    run_cmd(0, 3, 0,0,0,0, 0, 0, 0, 0, "R6");
    set_cfg(3, 1);
    run_cmd(0, 3, 0,0,0,0, 0, 0, 0, 0, "R6");
    set_cfg(0, 0);
    run_cmd(0, 0, 0,0,0,0, 0, 0, 0, 0, "R6");
    run_cmd(0, 1, 0,0,0,0, 0, 0, 0, 0, "R6");
    set_cfg(0, 50);
    run_cmd(0, 4, 0,0,0,0, 1, 16'h1234, 16'h1235, 16'h0001, "R7");
    run_cmd(0, 4, 0,0,0,0, 1, 16'h1234, 16'h1235, 16'h0000, "R7");
    run_cmd(0, 4, 0,0,0,0, 0, 16'h1234, 16'hffff, 16'h0000, "R7");
    run_cmd(0, 2, 1,0,0,0, 0, 0, 0, 0, "R8");
    run_cmd(0, 2, 1,1,0,0, 1, 16'h0000, 16'hffff, 16'h0000, "R8");
    run_cmd(0, 2, 0,1,0,0, 0, 0, 0, 0, "R8");
    run_cmd(1, 3, 0,0,1,0, 0, 0, 0, 0, "R8");
    run_cmd(2, 3, 0,0,1,1, 0, 0, 0, 0, "R8");
    run_cmd(0, 3, 0,0,0,1, 0, 0, 0, 0, "R8");

    set_cfg(0, 6); set_cfg(1, 5); set_cfg(2, 7);
    for (int n = 0; n < 40; n++) begin
      logic [15:0] d, e, m;
      d = 16'($urandom);
      e = d ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      m = 16'($urandom);
      run_cmd(int'($urandom % 4), int'($urandom % 10),
              ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
              1'($urandom), d, e, m, "R7");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule